// File: doc/BRIEF.md
# Speculative Fall-Through Flush Controller

This block is the control logic of a five-stage in-order pipeline: instruction fetch, decode, operand fetch, ALU operation and result writeback. Fetch always runs on sequentially past a branch, on the guess that the branch will not be taken. The controller follows which stage slots are occupied and carries a small tag with each slot. When a branch resolves in the ALU stage, it decides whether instructions must be squashed.

When a branch resolves as taken, the controller flushes every younger slot. These are the three stages upstream of the ALU and the fetch offered in that same cycle. On the following clock it raises a one-cycle redirect carrying the branch target. The refetch loses four slots per taken branch. A not-taken branch costs nothing. Four saturating counters record elapsed cycles, retired instructions, resolved branches and taken branches, so software or a bench can derive the average CPI, 1 + 4·Pb·Pt, and the efficiency of the pipeline.

Top module: `spec_flush_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, all stage-valid bits, `retire_valid`, `redirect_valid` and all four counters are cleared. Reset is synchronous.
- R2: Without a taken branch, an instruction offered with `fetch_valid` high in cycle k appears on `retire_valid`/`retire_tag` in cycle k+5, with its tag unchanged and in fetch order.
- R3: A taken branch is `br_resolve` and `br_taken` high while `stage_valid[3]` (ALU) is set. It drives `flush[i]` high for each occupied stage i in 0..2 (bit 0 is fetch) in that cycle. After the edge, `stage_valid[3:0]` are all zero and the fetch offered in that cycle is dropped.
- R4: `redirect_valid` is high for exactly the one cycle after a taken branch, with `redirect_pc` equal to the `br_target` given with it. It is low in every other cycle.
- R5: A not-taken resolution flushes nothing, raises no redirect and loses no slot; the pipeline stays full.
- R6: `br_resolve` while the ALU stage is empty is ignored: no flush, no redirect, and the branch counters are unchanged.
- R7: No squashed instruction ever appears on `retire_valid`.
- R8: `cnt_cycles` increments on every clock out of reset; `cnt_retired` on every retirement; `cnt_branches` on every resolution with the ALU stage occupied; `cnt_taken` on every taken branch.
- R9: Each counter holds at its all-ones value instead of wrapping.
- R10: With fetch offered every cycle, once the pipeline has drained the bubbles of the last taken branch, `cnt_cycles` equals `cnt_retired + 4*cnt_taken + 5`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fetch_valid | input | 1 | An instruction is offered to the fetch stage this cycle |
| fetch_tag | input | TAG_W | Tag carried with the offered instruction |
| br_resolve | input | 1 | The ALU-stage instruction is a branch resolving now |
| br_taken | input | 1 | The resolving branch is taken |
| br_target | input | PC_W | Target address of the resolving branch |
| stage_valid | output | STAGES | Occupancy per stage, bit 0 fetch to bit 4 writeback |
| flush | output | BR_STAGE | Per-stage squash for the stages younger than the ALU |
| redirect_valid | output | 1 | Fetch must restart at `redirect_pc` |
| redirect_pc | output | PC_W | Restart address |
| retire_valid | output | 1 | Writeback slot holds a live instruction |
| retire_tag | output | TAG_W | Tag of the retiring instruction |
| cnt_cycles | output | CNT_W | Saturating cycle count |
| cnt_retired | output | CNT_W | Saturating retirement count |
| cnt_branches | output | CNT_W | Saturating resolved-branch count |
| cnt_taken | output | CNT_W | Saturating taken-branch count |

## Verification
A taken resolution always coincides with a fetch offer. Flushing the young stages and rejecting that fetch therefore fall in the same cycle, as does the retirement of an older instruction from writeback. The bench keeps fetch asserted every cycle while random branches resolve. Its scoreboard removes the four entries fetched in the window of a taken branch and checks the rest in order at writeback five cycles after fetch. A lost, duplicated or leaked instruction shows up as a tag or latency mismatch. The cycle identity of R10 then confirms that exactly four slots were lost per taken branch.

// File: rtl/spec_flush_pkg.sv
// Package: shared stage numbering and counter helpers for the flush controller.
// Assumes the five-stage order fetch, decode, operand fetch, ALU, writeback.
package spec_flush_pkg;

    typedef enum int {
        STG_FETCH = 0,
        STG_DECODE = 1,
        STG_OPFETCH = 2,
        STG_ALU = 3,
        STG_WB = 4
    } stage_e;

    typedef enum int {
        CNT_CYC = 0,
        CNT_RET = 1,
        CNT_BR = 2,
        CNT_TK = 3
    } cnt_sel_e;

    localparam int NUM_CNT = 4;

endpackage

// File: rtl/spec_stage_track.sv
// Module: spec_stage_track
// Tracks occupancy and tag of each pipeline slot. A kill squashes every slot
// younger than the branch stage and drops the fetch offered in that cycle.
// Assumes BR_STAGE < STAGES-1 so that writeback follows the branch stage.
module spec_stage_track #(
    parameter int STAGES   = 5,
    parameter int BR_STAGE = 3,
    parameter int TAG_W    = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    fetch_valid,
    input  logic [TAG_W-1:0]        fetch_tag,
    input  logic                    kill,
    output logic [STAGES-1:0]       valid,
    output logic [STAGES*TAG_W-1:0] tags
);

    logic [TAG_W-1:0] tg [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_head
            // Entry slot: accept the offered fetch unless it is on the wrong path.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    valid[i] <= 1'b0;
                    tg[i]    <= '0;
                end else begin
                    valid[i] <= fetch_valid & ~kill;
                    tg[i]    <= fetch_tag;
                end
            end
        end else if (i <= BR_STAGE) begin : g_young
            // Slots up to the branch stage: inherit from upstream, cleared on kill.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    valid[i] <= 1'b0;
                    tg[i]    <= '0;
                end else begin
                    valid[i] <= valid[i-1] & ~kill;
                    tg[i]    <= tg[i-1];
                end
            end
        end else begin : g_old
            // Slots past the branch stage: advance unconditionally.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    valid[i] <= 1'b0;
                    tg[i]    <= '0;
                end else begin
                    valid[i] <= valid[i-1];
                    tg[i]    <= tg[i-1];
                end
            end
        end
        assign tags[i*TAG_W +: TAG_W] = tg[i];
    end

    // R3: a kill leaves every slot up to the branch stage empty after the edge.
    p_squash_r3: assert property (@(posedge clk) disable iff (!rst_n)
        kill |=> (valid[BR_STAGE:0] == '0))
        else $error("p_squash_r3");

    // R2: a live slot in front of writeback always reaches it with its tag.
    p_advance_r2: assert property (@(posedge clk) disable iff (!rst_n)
        valid[STAGES-2] |=> (valid[STAGES-1] && tg[STAGES-1] == $past(tg[STAGES-2])))
        else $error("p_advance_r2");

endmodule

// File: rtl/spec_redirect.sv
// Module: spec_redirect
// Registers the fetch redirect one clock after a taken branch resolves.
// Assumes the caller qualifies taken_hit with an occupied branch stage.
module spec_redirect #(
    parameter int PC_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            taken_hit,
    input  logic [PC_W-1:0] target,
    output logic            redirect_valid,
    output logic [PC_W-1:0] redirect_pc
);

    // Capture the target and pulse the redirect for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            redirect_valid <= 1'b0;
            redirect_pc    <= '0;
        end else begin
            redirect_valid <= taken_hit;
            if (taken_hit) begin
                redirect_pc <= target;
            end
        end
    end

    p_redirect_follows_r4: assert property (@(posedge clk) disable iff (!rst_n)
        taken_hit |=> (redirect_valid && redirect_pc == $past(target)))
        else $error("p_redirect_follows_r4");

    p_redirect_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !taken_hit |=> !redirect_valid)
        else $error("p_redirect_quiet_r4");

endmodule

// File: rtl/spec_sat_counter.sv
// Module: spec_sat_counter
// Event counter that sticks at all-ones. Assumes one event per clock at most.
module spec_sat_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] cnt
);

    localparam logic [W-1:0] MAX = '1;

    // Count one event per clock, holding once the ceiling is reached.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (inc && cnt != MAX) begin
            cnt <= cnt + 1'b1;
        end
    end

    p_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && cnt != MAX) |=> (cnt == $past(cnt) + 1'b1))
        else $error("p_step_r8");

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !inc |=> $stable(cnt))
        else $error("p_hold_r8");

    p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == MAX) |=> (cnt == MAX))
        else $error("p_no_overflow_r9");

endmodule

// File: rtl/spec_flush_ctrl.sv
// Module: spec_flush_ctrl (top)
// Squashes wrong-path work in a predict-fall-through pipeline and counts
// cycles, retirements, branches and taken branches. Branches resolve in the
// ALU stage; flush acts at the next edge, the redirect shows one cycle later.
// Assumes the fetch unit refetches from redirect_pc in the redirect cycle.
module spec_flush_ctrl
    import spec_flush_pkg::*;
#(
    parameter int STAGES   = 5,
    parameter int BR_STAGE = int'(STG_ALU),
    parameter int TAG_W    = 8,
    parameter int PC_W     = 32,
    parameter int CNT_W    = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                fetch_valid,
    input  logic [TAG_W-1:0]    fetch_tag,
    input  logic                br_resolve,
    input  logic                br_taken,
    input  logic [PC_W-1:0]     br_target,
    output logic [STAGES-1:0]   stage_valid,
    output logic [BR_STAGE-1:0] flush,
    output logic                redirect_valid,
    output logic [PC_W-1:0]     redirect_pc,
    output logic                retire_valid,
    output logic [TAG_W-1:0]    retire_tag,
    output logic [CNT_W-1:0]    cnt_cycles,
    output logic [CNT_W-1:0]    cnt_retired,
    output logic [CNT_W-1:0]    cnt_branches,
    output logic [CNT_W-1:0]    cnt_taken
);

    localparam int PENALTY = BR_STAGE + 1;
    localparam int WB      = STAGES - 1;

    logic                    br_hit;
    logic                    taken_hit;
    logic [STAGES*TAG_W-1:0] tags;
    logic [NUM_CNT-1:0]      cnt_inc;
    logic [CNT_W-1:0]        cnt_val [NUM_CNT];

    // Qualify the resolution with an occupied branch stage.
    always_comb begin
        br_hit    = br_resolve & stage_valid[BR_STAGE];
        taken_hit = br_hit & br_taken;
        flush     = {BR_STAGE{taken_hit}} & stage_valid[BR_STAGE-1:0];
    end

    spec_stage_track #(
        .STAGES  (STAGES),
        .BR_STAGE(BR_STAGE),
        .TAG_W   (TAG_W)
    ) u_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .fetch_valid(fetch_valid),
        .fetch_tag  (fetch_tag),
        .kill       (taken_hit),
        .valid      (stage_valid),
        .tags       (tags)
    );

    spec_redirect #(
        .PC_W(PC_W)
    ) u_redir (
        .clk           (clk),
        .rst_n         (rst_n),
        .taken_hit     (taken_hit),
        .target        (br_target),
        .redirect_valid(redirect_valid),
        .redirect_pc   (redirect_pc)
    );

    assign retire_valid = stage_valid[WB];
    assign retire_tag   = tags[WB*TAG_W +: TAG_W];

    // Select the event feeding each performance counter.
    always_comb begin
        cnt_inc         = '0;
        cnt_inc[CNT_CYC] = 1'b1;
        cnt_inc[CNT_RET] = retire_valid;
        cnt_inc[CNT_BR]  = br_hit;
        cnt_inc[CNT_TK]  = taken_hit;
    end

    for (genvar c = 0; c < NUM_CNT; c++) begin : g_cnt
        spec_sat_counter #(
            .W(CNT_W)
        ) u_cnt (
            .clk  (clk),
            .rst_n(rst_n),
            .inc  (cnt_inc[c]),
            .cnt  (cnt_val[c])
        );
    end

    assign cnt_cycles   = cnt_val[CNT_CYC];
    assign cnt_retired  = cnt_val[CNT_RET];
    assign cnt_branches = cnt_val[CNT_BR];
    assign cnt_taken    = cnt_val[CNT_TK];

    // R6: a resolution with an empty branch stage must not redirect.
    p_ignore_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (br_resolve && !stage_valid[BR_STAGE]) |=> !redirect_valid)
        else $error("p_ignore_empty_r6");

    // R7: the branch slot is empty right after a taken branch, so the squash
    // window of PENALTY slots cannot be reopened by a second resolution.
    p_no_leak_r7: assert property (@(posedge clk) disable iff (!rst_n)
        taken_hit |=> !stage_valid[BR_STAGE])
        else $error("p_no_leak_r7");

    // R1: the first cycle after a reset edge shows an empty pipeline.
    p_reset_empty_r1: assert property (@(posedge clk)
        !rst_n |=> (stage_valid == '0 && !redirect_valid && cnt_cycles == '0))
        else $error("p_reset_empty_r1");

    initial begin
        if (PENALTY != BR_STAGE + 1 || BR_STAGE >= WB) begin
            $error("spec_flush_ctrl: branch stage must precede writeback");
        end
    end

endmodule

// File: tb/spec_flush_ctrl_tb.sv
module spec_flush_ctrl_tb;

    localparam int BR_PCT    = 25;
    localparam int TAKEN_PCT = 50;
    localparam int LAST      = 1500;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        fetch_valid;
    logic [7:0]  fetch_tag;
    logic        br_resolve;
    logic        br_taken;
    logic [31:0] br_target;
    logic [4:0]  stage_valid;
    logic [2:0]  flush;
    logic        redirect_valid;
    logic [31:0] redirect_pc;
    logic        retire_valid;
    logic [7:0]  retire_tag;
    logic [31:0] cnt_cycles, cnt_retired, cnt_branches, cnt_taken;
    logic [4:0]  s_sv;
    logic [2:0]  s_fl;
    logic        s_rv, s_rt;
    logic [7:0]  s_tag;
    logic [31:0] s_pc;
    logic [3:0]  s_cy, s_re, s_br, s_tk;

    always #5 clk = ~clk;

    spec_flush_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_tag(fetch_tag),
        .br_resolve(br_resolve), .br_taken(br_taken), .br_target(br_target),
        .stage_valid(stage_valid), .flush(flush), .redirect_valid(redirect_valid),
        .redirect_pc(redirect_pc), .retire_valid(retire_valid), .retire_tag(retire_tag),
        .cnt_cycles(cnt_cycles), .cnt_retired(cnt_retired),
        .cnt_branches(cnt_branches), .cnt_taken(cnt_taken)
    );

    // Narrow-counter copy used only to reach the saturation ceiling.
    spec_flush_ctrl #(.CNT_W(4)) u_sat (
        .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_tag(fetch_tag),
        .br_resolve(br_resolve), .br_taken(br_taken), .br_target(br_target),
        .stage_valid(s_sv), .flush(s_fl), .redirect_valid(s_rv),
        .redirect_pc(s_pc), .retire_valid(s_rt), .retire_tag(s_tag),
        .cnt_cycles(s_cy), .cnt_retired(s_re), .cnt_branches(s_br), .cnt_taken(s_tk)
    );

    typedef struct {
        logic [7:0] tag;
        int         cyc;
    } item_t;

    item_t q[$];
    int checks = 0;
    int errors = 0;
    int nret = 0;
    int mcyc = 0;

    task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    // Monitor: pop the scoreboard at each retirement, check tag and latency.
    always @(posedge clk) begin
        if (rst_n) begin
            mcyc++;
            #2;
            if (retire_valid) begin
                nret++;
                if (q.size() == 0) begin
                    chk(1'b0, "R7 retire with empty scoreboard", retire_tag, -1);
                end else begin
                    item_t e;
                    e = q.pop_front();
                    chk(retire_tag == e.tag, "R7 retire tag", retire_tag, e.tag);
                    chk(mcyc - e.cyc == 5, "R2 retire latency", mcyc - e.cyc, 5);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        #200us;
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Driver: one iteration per negedge; pushes expected retirements.
    initial begin
        int nbr = 0;
        int ntk = 0;
        int last_tk = -10;
        logic [31:0] last_tgt = '0;
        rst_n = 1'b0;
        fetch_valid = 1'b0;
        fetch_tag = '0;
        br_resolve = 1'b0;
        br_taken = 1'b0;
        br_target = '0;
        repeat (3) @(negedge clk);
        chk(stage_valid == 0, "R1 stage_valid in reset", stage_valid, 0);
        chk(!retire_valid && !redirect_valid, "R1 strobes in reset",
            {retire_valid, redirect_valid}, 0);
        chk(cnt_cycles == 0 && cnt_retired == 0 && cnt_branches == 0 && cnt_taken == 0,
            "R1 counters in reset", cnt_cycles + cnt_retired + cnt_branches + cnt_taken, 0);
        @(negedge clk);
        rst_n = 1'b1;
        for (int k = 0; k <= LAST; k++) begin
            logic [4:0] sv;
            bit res, tk;
            if (k > 0) @(negedge clk);
            sv = stage_valid;
            // R4: redirect only in the cycle after a taken branch.
            chk(redirect_valid == (k == last_tk + 1), "R4 redirect timing",
                redirect_valid, k == last_tk + 1);
            if (k == last_tk + 1) begin
                chk(redirect_pc == last_tgt, "R4 redirect target", redirect_pc, last_tgt);
            end
            if (k == 2) chk(cnt_branches == 0, "R6 empty-stage resolve not counted", cnt_branches, 0);
            if (k == 5) begin
                chk(cnt_branches == 1 && cnt_taken == 0, "R8 not-taken counted",
                    cnt_branches * 10 + cnt_taken, 10);
                chk(stage_valid == 5'b11111, "R5 pipeline full after not-taken", stage_valid, 31);
            end
            if (k == 7) begin
                chk(stage_valid[3:0] == 0, "R3 young stages squashed", stage_valid[3:0], 0);
                chk(cnt_taken == 1, "R8 taken counted", cnt_taken, 1);
            end
            res = 1'b0;
            tk = 1'b0;
            if (k == 1) begin
                res = 1'b1; tk = 1'b1;
            end else if (k == 4) begin
                res = 1'b1; tk = 1'b0;
            end else if (k == 6) begin
                res = 1'b1; tk = 1'b1;
            end else if (k >= 20 && k < LAST - 12 && sv[3]) begin
                res = ($urandom_range(99) < BR_PCT);
                tk = res && ($urandom_range(99) < TAKEN_PCT);
            end
            br_resolve = res;
            br_taken = tk;
            br_target = 32'h1000 + 32'(k) * 4;
            fetch_valid = 1'b1;
            fetch_tag = k[7:0];
            #1;
            if (res && tk && sv[3]) begin
                chk(flush == sv[2:0], "R3 flush of occupied young stages", flush, sv[2:0]);
            end else begin
                chk(flush == 0, "R5 R6 no flush", flush, 0);
            end
            if (k == 6) chk(flush == 3'b111, "R3 full flush", flush, 7);
            if (res && sv[3]) begin
                nbr++;
                if (tk) begin
                    ntk++;
                    last_tk = k;
                    last_tgt = br_target;
                    while (q.size() > 0 && q[$].cyc >= k - 3) void'(q.pop_back());
                end
            end
            if (!(res && tk && sv[3])) q.push_back('{k[7:0], k});
        end
        chk(cnt_cycles == LAST, "R8 cycle counter", cnt_cycles, LAST);
        chk(cnt_retired == 32'(nret - int'(retire_valid)), "R8 retired counter",
            cnt_retired, nret - int'(retire_valid));
        chk(cnt_branches == nbr, "R8 branch counter", cnt_branches, nbr);
        chk(cnt_taken == ntk, "R8 taken counter", cnt_taken, ntk);
        chk(cnt_cycles == cnt_retired + 4 * cnt_taken + 5, "R10 cycle identity",
            cnt_cycles, cnt_retired + 4 * cnt_taken + 5);
        chk(ntk > 20, "R10 enough taken branches", ntk, 21);
        chk(s_cy == 4'hF, "R9 cycle counter saturates", s_cy, 15);
        chk(s_re == 4'hF, "R9 retired counter saturates", s_re, 15);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule